// File: doc/BRIEF.md
# Triggered Block Copy Engine

This block is a small memory-to-memory copy engine. Software first loads a control block through a register write port. The control block holds a block size, a source pointer, a destination pointer, a control byte and a count of blocks still to move. After that, each pulse on the trigger input copies one complete block of byte or word units through a byte-wide synchronous memory port. A block, once started, runs to its end without interruption. A trigger that arrives in the middle of a block is held and served as soon as the block finishes.

Each pointer can advance after every unit or stay fixed. At the end of each block, each pointer either keeps its advanced value or returns to the value it had when the block began. The engine decrements the block count at the end of every block. When the count reaches zero it raises an end-of-sequence interrupt, which stays high until software clears it. A trigger with an illegal setup moves no data and sets an error flag instead.

Top module: `blkmove_engine`

## Requirements
- R1: After reset, `busy`, `done_irq`, `setup_err`, `mem_re` and `mem_we` are all low.
- R2: The write port selects a field with `cfg_sel`. The select codes are 0 = block count (bits 7:0), 1 = control byte (bits 7:0), 2 = source pointer, 3 = destination pointer, 4 = block size (bits 5:0), and 5 = flag clear. A write to code 5 clears `done_irq` when bit 0 is set and clears `setup_err` when bit 1 is set.
- R3: The control byte is laid out as bits 7:5 = mode, bit 4 = unit width (1 = byte, 0 = word), bit 3 = source retain, bit 2 = destination retain, bit 1 = source advance, and bit 0 = destination advance. Only mode 001 is legal.
- R4: Each byte is moved in two cycles. In the first cycle `mem_re` reads the source. In the next cycle `mem_we` writes the returned byte to the destination. A word unit is moved as two bytes, low address first. `busy` is high for exactly 2 × size × (1 for byte units, 2 for word units) cycles per block.
- R5: When its advance bit is set, a pointer steps by 1 (byte units) or by 2 (word units) after every unit. When the bit is clear, the pointer stays fixed.
- R6: At the end of a block, a pointer whose retain bit is 0 returns to its value at the start of that block. A pointer whose retain bit is 1 keeps its advanced value for the next block.
- R7: The block count drops by one at the end of every block. The block that brings it to zero sets `done_irq`. `done_irq` stays high until a clear write, including across later triggers.
- R8: A trigger is rejected when the mode is not 001, when the size is 0 or above 32, or when word units are selected with an odd source or an odd destination. A rejected trigger sets `setup_err`, makes no memory access and leaves the count unchanged.
- R9: A trigger that arrives while the count is zero is ignored: no memory access, `busy` stays low, and no error is flagged.
- R10: A trigger that arrives while a block is running is held. Its block starts one idle cycle after the current block ends.
- R11: Writes to codes 0 to 4 while `busy` is high are ignored.
- R12: With size 5, source 0020h, destination 6000h, control byte 37h and count 3, three triggers copy bytes 20h–24h into 6000h–6004h, then into 6005h–6009h, then into 600Ah–600Eh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Field select for the write |
| cfg_wdata | input | 16 | Write data |
| trig | input | 1 | Block trigger pulse |
| mem_rdata | input | 8 | Read data, returned one cycle after `mem_re` |
| mem_addr | output | 16 | Byte address |
| mem_re | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Block in progress |
| done_irq | output | 1 | End-of-sequence interrupt |
| setup_err | output | 1 | Illegal setup seen on a trigger |

## Verification
The hardest state to reach from the ports is a second trigger held while a block is running. The write-port lockout only shows up in the same window. The stimulus pulses the trigger once, then writes a new source pointer and pulses the trigger again while `busy` is high. It then checks three things: the one idle cycle between the blocks, the continued use of the old pointer, and the interrupt after both blocks. The bench also sweeps all 32 width, retain and advance combinations at several sizes. It compares the whole memory against an arithmetic model of the pointer walk.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} st_e;

  typedef enum logic [2:0] {
    SEL_COUNT = 3'd0,
    SEL_CTRL  = 3'd1,
    SEL_SRC   = 3'd2,
    SEL_DST   = 3'd3,
    SEL_SIZE  = 3'd4,
    SEL_CLR   = 3'd5
  } sel_e;

  localparam logic [2:0] MODE_BLOCK = 3'b001;

  typedef struct packed {
    logic [2:0] mode;
    logic       bw;
    logic       src_keep;
    logic       dst_keep;
    logic       src_inc;
    logic       dst_inc;
  } ctrl_t;
endpackage

// File: rtl/blkmove_check.sv
module blkmove_check
  import blkmove_pkg::*;
#(
  parameter int SZW     = 6,
  parameter int MAX_BLK = 32
) (
  input  ctrl_t          ctrl,
  input  logic [SZW-1:0] size,
  input  logic           src_lsb,
  input  logic           dst_lsb,
  output logic           ok
);
  localparam logic [SZW-1:0] SIZE_MAX = SZW'(MAX_BLK);

  logic mode_ok, size_ok, align_ok;

  always_comb begin
    mode_ok  = (ctrl.mode == MODE_BLOCK);
    size_ok  = (size != '0) && (size <= SIZE_MAX);
    align_ok = ctrl.bw || (!src_lsb && !dst_lsb);
    ok       = mode_ok && size_ok && align_ok;
  end
endmodule

// File: rtl/blkmove_ptr.sv
module blkmove_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          snap,
  input  logic          adv,
  input  logic [1:0]    step,
  input  logic          restore,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_q, ptr_n, start_q, start_n;

  always_comb begin
    ptr_n   = ptr_q;
    start_n = start_q;
    if (ld)           ptr_n = ld_val;
    else if (restore) ptr_n = start_q;
    else if (adv)     ptr_n = ptr_q + AW'(step);
    if (snap)         start_n = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      start_q <= '0;
    end else begin
      ptr_q   <= ptr_n;
      start_q <= start_n;
    end
  end

  assign ptr = ptr_q;

  // R6: a non-retained pointer comes back to its start value
  a_r6_restore_start: assert property (@(posedge clk) disable iff (!rst_n)
    (restore && !ld) |=> (ptr_q == $past(start_q)));
endmodule

// File: rtl/blkmove_xfer.sv
module blkmove_xfer
  import blkmove_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CNTW = 8,
  parameter int SZW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          trig,
  input  logic          setup_ok,
  input  logic [AW-1:0] src_ptr,
  input  logic [AW-1:0] dst_ptr,
  input  logic [7:0]    mem_rdata,
  output ctrl_t         ctrl,
  output logic [SZW-1:0] size,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  output logic          busy,
  output logic          irq,
  output logic          err,
  output logic          snap,
  output logic          unit_done,
  output logic          blk_end,
  output logic [1:0]    step,
  output logic          wr_ok
);
  st_e            st_q, st_n;
  logic           hi_q, hi_n;
  logic [SZW-1:0] left_q, left_n, size_q, size_n;
  logic [CNTW-1:0] cnt_q, cnt_n;
  ctrl_t          ctrl_q, ctrl_n;
  logic           irq_q, irq_n, err_q, err_n, pend_q, pend_n;
  logic           idle, clr, go_req, start, reject, last_byte;

  always_comb begin
    idle      = (st_q == ST_IDLE);
    wr_ok     = cfg_we && idle;
    clr       = cfg_we && (cfg_sel == SEL_CLR);
    go_req    = idle && (trig || pend_q) && (cnt_q != '0);
    start     = go_req && setup_ok;
    reject    = go_req && !setup_ok;
    last_byte = ctrl_q.bw || hi_q;
    unit_done = (st_q == ST_WR) && last_byte;
    blk_end   = unit_done && (left_q == SZW'(1));
    step      = ctrl_q.bw ? 2'd1 : 2'd2;
    snap      = start;
    mem_re    = (st_q == ST_RD);
    mem_we    = (st_q == ST_WR);
    mem_addr  = (mem_re ? src_ptr : dst_ptr) + AW'(hi_q);
    mem_wdata = mem_rdata;
    busy      = !idle;
  end

  always_comb begin
    st_n   = st_q;
    hi_n   = hi_q;
    left_n = left_q;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_n   = ST_RD;
        hi_n   = 1'b0;
        left_n = size_q;
      end
      ST_RD: st_n = ST_WR;
      ST_WR: begin
        if (!last_byte) begin
          hi_n = 1'b1;
          st_n = ST_RD;
        end else begin
          hi_n   = 1'b0;
          left_n = left_q - SZW'(1);
          st_n   = (left_q == SZW'(1)) ? ST_IDLE : ST_RD;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_comb begin
    pend_n = pend_q;
    if (busy && trig) pend_n = 1'b1;
    else if (idle)    pend_n = 1'b0;

    cnt_n = cnt_q;
    if (wr_ok && cfg_sel == SEL_COUNT) cnt_n = cfg_wdata[CNTW-1:0];
    else if (blk_end)                  cnt_n = cnt_q - CNTW'(1);

    ctrl_n = (wr_ok && cfg_sel == SEL_CTRL) ? ctrl_t'(cfg_wdata[7:0]) : ctrl_q;
    size_n = (wr_ok && cfg_sel == SEL_SIZE) ? cfg_wdata[SZW-1:0] : size_q;

    irq_n = irq_q;
    if (blk_end && cnt_q == CNTW'(1)) irq_n = 1'b1;
    else if (clr && cfg_wdata[0])     irq_n = 1'b0;

    err_n = err_q;
    if (reject)                   err_n = 1'b1;
    else if (clr && cfg_wdata[1]) err_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hi_q   <= 1'b0;
      left_q <= '0;
      size_q <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      hi_q   <= hi_n;
      left_q <= left_n;
      size_q <= size_n;
      cnt_q  <= cnt_n;
      ctrl_q <= ctrl_n;
      irq_q  <= irq_n;
      err_q  <= err_n;
      pend_q <= pend_n;
    end
  end

  assign ctrl = ctrl_q;
  assign size = size_q;
  assign irq  = irq_q;
  assign err  = err_q;

  // R4: never read and write in one cycle; every write follows a read
  a_r4_rw_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
  a_r4_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_re));
  // R9: a block never starts from a zero count
  a_r9_no_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cnt_q) != '0));
  // R8: a rejected trigger leaves the engine idle
  a_r8_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy);
  // R7: the interrupt rises only when the count has run out
  a_r7_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (cnt_q == '0));
endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine
  import blkmove_pkg::*;
#(
  parameter int AW      = 16,
  parameter int CNTW    = 8,
  parameter int MAX_BLK = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          trig,
  input  logic [7:0]    mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  output logic          busy,
  output logic          done_irq,
  output logic          setup_err
);
  localparam int SZW  = $clog2(MAX_BLK) + 1;
  localparam int NPTR = 2;

  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  ctrl_t          ctrl;
  logic [SZW-1:0] size;
  logic           setup_ok, snap, unit_done, blk_end, wr_ok;
  logic [1:0]     step;
  logic [AW-1:0]  ptr [NPTR];

  blkmove_check #(.SZW(SZW), .MAX_BLK(MAX_BLK)) u_chk (
    .ctrl(ctrl), .size(size), .src_lsb(ptr[0][0]), .dst_lsb(ptr[1][0]),
    .ok(setup_ok)
  );

  blkmove_xfer #(.AW(AW), .CNTW(CNTW), .SZW(SZW)) u_xfer (
    .clk(clk), .rst_n(rst_n_i), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .trig(trig), .setup_ok(setup_ok),
    .src_ptr(ptr[0]), .dst_ptr(ptr[1]), .mem_rdata(mem_rdata),
    .ctrl(ctrl), .size(size), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .busy(busy), .irq(done_irq),
    .err(setup_err), .snap(snap), .unit_done(unit_done), .blk_end(blk_end),
    .step(step), .wr_ok(wr_ok)
  );

  for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
    localparam sel_e MY_SEL = (gi == 0) ? SEL_SRC : SEL_DST;
    logic inc_bit, keep_bit;
    assign inc_bit  = (gi == 0) ? ctrl.src_inc  : ctrl.dst_inc;
    assign keep_bit = (gi == 0) ? ctrl.src_keep : ctrl.dst_keep;

    blkmove_ptr #(.AW(AW)) u_ptr (
      .clk(clk), .rst_n(rst_n_i),
      .ld(wr_ok && cfg_sel == MY_SEL), .ld_val(cfg_wdata),
      .snap(snap), .adv(unit_done && inc_bit), .step(step),
      .restore(blk_end && !keep_bit), .ptr(ptr[gi])
    );
  end
endmodule

// File: tb/blkmove_engine_tb.sv
module blkmove_engine_tb;
  localparam int MW = 1024;

  logic        clk, rst_n, cfg_we, trig;
  logic [2:0]  cfg_sel;
  logic [15:0] cfg_wdata, mem_addr;
  logic [7:0]  mem_rdata, mem_wdata;
  logic        mem_re, mem_we, busy, done_irq, setup_err;

  logic [7:0] mem [MW];
  logic [7:0] expm [MW];
  int n_chk, n_fail;
  bit done;

  blkmove_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .trig(trig), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .busy(busy), .done_irq(done_irq),
    .setup_err(setup_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
  end

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic mem_init();
    for (int i = 0; i < MW; i++) begin
      mem[i] = pat(i);
      expm[i] = pat(i);
    end
  endtask

  task automatic mem_cmp(input string req);
    int bad = 0;
    for (int i = 0; i < MW; i++) if (mem[i] !== expm[i]) bad++;
    check(bad == 0, req, bad, 0);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic pulse_wait(output int cyc);
    pulse();
    cyc = 0;
    while (busy) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic run_cfg(input logic [4:0] c, input int sz, input int src0,
                         input int dst0, input int nblk);
    int nb, s, d, ss, dd, cyc;
    nb = c[4] ? 1 : 2;
    s = src0; d = dst0;
    mem_init();
    wr(3'd0, 16'(nblk));
    wr(3'd1, {8'h0, 3'b001, c});
    wr(3'd2, 16'(src0));
    wr(3'd3, 16'(dst0));
    wr(3'd4, 16'(sz));
    for (int b = 0; b < nblk; b++) begin
      pulse_wait(cyc);
      check(cyc == 2 * sz * nb, "R4 busy cycles per block", cyc, 2 * sz * nb);
      check(done_irq == (b == nblk - 1), "R7 interrupt after last block",
            int'(done_irq), int'(b == nblk - 1));
      ss = s; dd = d;
      for (int u = 0; u < sz; u++) begin
        for (int k = 0; k < nb; k++) expm[(d + k) % MW] = expm[(s + k) % MW];
        if (c[1]) s += nb;
        if (c[0]) d += nb;
      end
      if (!c[3]) s = ss;
      if (!c[2]) d = dd;
    end
    mem_cmp("R3 R5 R6 memory after block sequence");
    check(setup_err == 1'b0, "R8 no error on legal setup", int'(setup_err), 0);
    wr(3'd5, 16'h0001);
    @(negedge clk);
    check(done_irq == 1'b0, "R2 R7 interrupt cleared by write", int'(done_irq), 0);
  endtask

  task automatic reject_case(input logic [7:0] ctl, input int sz, input int src0,
                             input int dst0, input string req);
    wr(3'd1, {8'h0, ctl});
    wr(3'd4, 16'(sz));
    wr(3'd2, 16'(src0));
    wr(3'd3, 16'(dst0));
    pulse();
    check(setup_err == 1'b1 && busy == 1'b0, req, int'(setup_err), 1);
    mem_cmp("R8 no memory access on reject");
    wr(3'd5, 16'h0002);
    @(negedge clk);
    check(setup_err == 1'b0, "R2 R8 error cleared by write", int'(setup_err), 0);
  endtask

  initial begin
    done = 1'b0;
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int cyc;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0; trig = 1'b0;
    mem_init();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done_irq && !setup_err && !mem_re && !mem_we,
          "R1 reset state", int'({busy, done_irq, setup_err, mem_re, mem_we}), 0);

    // R12: worked example, expected bytes listed directly
    mem_init();
    wr(3'd0, 16'd3); wr(3'd1, 16'h0037); wr(3'd2, 16'h0020);
    wr(3'd3, 16'h6000); wr(3'd4, 16'd5);
    for (int b = 0; b < 3; b++) pulse_wait(cyc);
    begin
      int bad = 0;
      for (int b = 0; b < 3; b++)
        for (int i = 0; i < 5; i++)
          if (mem[5 * b + i] !== pat(32 + i)) bad++;
      check(bad == 0, "R12 example three blocks", bad, 0);
    end
    check(done_irq == 1'b1, "R7 R12 interrupt after three blocks", int'(done_irq), 1);

    // R9: trigger with zero count is ignored, interrupt stays high
    mem_init();
    pulse();
    check(busy == 1'b0 && setup_err == 1'b0, "R9 zero count trigger ignored",
          int'(busy), 0);
    mem_cmp("R9 no memory access with zero count");
    check(done_irq == 1'b1, "R7 interrupt held across later trigger", int'(done_irq), 1);
    wr(3'd5, 16'h0001);

    // R3 R5 R6: sweep every width/retain/advance combination
    for (int c = 0; c < 32; c++) begin
      run_cfg(5'(c), 1, 16'h0020, 16'h6200, 2);
      run_cfg(5'(c), 3, 16'h0020, 16'h6200, 2);
    end
    run_cfg(5'b01111, 32, 16'h0020, 16'h6200, 2);
    run_cfg(5'b11111, 32, 16'h0021, 16'h6201, 2);

    // R8: illegal setups; count is loaded with 1 beforehand
    mem_init();
    wr(3'd0, 16'd1);
    reject_case(8'h5F, 4, 16'h0020, 16'h6200, "R3 R8 bad mode rejected");
    reject_case(8'h3F, 0, 16'h0020, 16'h6200, "R8 size zero rejected");
    reject_case(8'h3F, 33, 16'h0020, 16'h6200, "R8 size above 32 rejected");
    reject_case(8'h2F, 2, 16'h0021, 16'h6200, "R8 odd word source rejected");
    reject_case(8'h2F, 2, 16'h0020, 16'h6201, "R8 odd word destination rejected");
    wr(3'd1, 16'h003F); wr(3'd4, 16'd2);
    pulse_wait(cyc);
    check(done_irq == 1'b1, "R8 count unchanged by rejects", int'(done_irq), 1);
    wr(3'd5, 16'h0001);

    // R10 R11: second trigger and a pointer write while busy
    mem_init();
    wr(3'd0, 16'd2); wr(3'd1, 16'h003F); wr(3'd2, 16'h0040);
    wr(3'd3, 16'h6300); wr(3'd4, 16'd4);
    pulse();
    wr(3'd2, 16'h0100);
    pulse();
    while (busy) @(negedge clk);
    check(busy == 1'b0, "R10 one idle cycle between blocks", int'(busy), 0);
    @(negedge clk);
    check(busy == 1'b1, "R10 held trigger starts next block", int'(busy), 1);
    while (busy) @(negedge clk);
    for (int i = 0; i < 8; i++) expm[(16'h6300 + i) % MW] = pat(16'h40 + i);
    mem_cmp("R10 R11 both blocks use original source");
    check(done_irq == 1'b1, "R10 interrupt after held block", int'(done_irq), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule